// File: doc/BRIEF.md
# Regulator Protection Supervisor

This block is the digital protection supervisor of a supply-output regulator. It takes comparator flags that have already been synchronized to its clock (overcurrent, die too hot, die cooled, temperature warning, load current present, output in range, pass element running). From them it decides whether the regulator may drive its output. It also assembles the status byte that the host reads and drives an active-low, open-drain fault line.

A sustained overcurrent is handled by a hiccup cycle. The output stays clamped and enabled for a programmable on-window. If the overcurrent is still there when the window ends, the output is switched off for a programmable rest window, and the block then tries again. A thermal trip disables the output until the cool flag asserts. The thermal-trip and overcurrent-trip bits are sticky and hold the fault line low. In register-control mode a status read clears them. In pin-control mode a low-to-high cycle of the enable pin clears them. Both windows are counted in pulses of a system tick input, so a shortened setting can be used.

Top module: `lnb_prot_supervisor`

## Requirements
- R1: While reset is asserted, reg_en_o is 0 and status bits 3 and 2 (thermal-trip and overcurrent-trip) are 0.
- R2: When overcurrent persists, reg_en_o stays 1 for ON_TICKS ticks after the edge at which the clamp begins. If overcurrent is still present on the last of those ticks, reg_en_o drops to 0 and status bit 2 becomes 1 at that edge.
- R3: After an overcurrent shutdown, reg_en_o stays 0 for OFF_TICKS ticks and then returns to 1 (retry). Both windows advance only on cycles where tick_i is 1.
- R4: If overcurrent goes away before the on-window ends, the output stays enabled and status bit 2 is not set.
- R5: hot_flag_i forces reg_en_o to 0 from the next edge. The output stays off after hot_flag_i falls, and is re-enabled only at the edge after cool_flag_i is seen while hot_flag_i is 0.
- R6: Status bits 3 and 2 are sticky. With ctrl_mode_i = 1, a one-cycle status_rd_i pulse clears both at the next edge.
- R7: With ctrl_mode_i = 0, status_rd_i has no effect on the sticky bits. A rising edge of en_pin_i (low in one cycle, high in the next) clears them.
- R8: If a trip event and a clearing action fall in the same cycle, the sticky bit stays 1.
- R9: Status byte layout: bit 7 = 0, bit 6 = warm_flag_i, bit 5 = ldo_on_i, bit 4 = 0, bit 3 = thermal-trip, bit 2 = overcurrent-trip, bit 1 = cable_flag_i (load above threshold), bit 0 = vgood_flag_i. Non-sticky bits follow their inputs in the same cycle.
- R10: fault_n_o is 0 exactly when thermal-trip or overcurrent-trip is set, or warm_flag_i is 1, or vgood_flag_i is 0. Otherwise it is 1 (released).
- R11: While en_pin_i or out_en_bit_i is 0, reg_en_o is 0 and the hiccup sequence returns to idle. When both are high again, the output is enabled at the next edge without finishing any pending rest window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | Timebase pulse that advances the hiccup windows |
| ctrl_mode_i | input | 1 | 1: register control (read clears), 0: pin control (enable cycle clears) |
| out_en_bit_i | input | 1 | Output-enable bit from the control register |
| en_pin_i | input | 1 | Synchronized enable pin |
| status_rd_i | input | 1 | One-cycle pulse when the host reads the status byte |
| ocp_flag_i | input | 1 | Overcurrent comparator flag |
| hot_flag_i | input | 1 | Die over the shutdown temperature |
| cool_flag_i | input | 1 | Die below the restart temperature |
| warm_flag_i | input | 1 | Die over the warning temperature |
| cable_flag_i | input | 1 | Load current above the connection threshold |
| vgood_flag_i | input | 1 | Output voltage within its window |
| ldo_on_i | input | 1 | Pass regulator running |
| reg_en_o | output | 1 | Enable to the output regulator |
| status_o | output | 8 | Status byte |
| fault_n_o | output | 1 | Fault line, 0 = pull low |

## Verification
The assertions assume that every flag is already synchronized and that status_rd_i is a single-cycle pulse. They also assume hot_flag_i has priority whenever both temperature flags are seen together. The stimulus drives all inputs one time unit after a clock edge and never asserts the two temperature flags at once. It pulses status_rd_i for exactly one cycle. In the random phase it varies only the non-sticky flags and the tick, so the sticky bits stay at their known cleared value there.

// File: rtl/lnb_prot_pkg.sv
`timescale 1ns/1ps
package lnb_prot_pkg;
  typedef enum logic [1:0] {
    HC_IDLE  = 2'd0,
    HC_RUN   = 2'd1,
    HC_CLAMP = 2'd2,
    HC_OFF   = 2'd3
  } hc_state_e;

  localparam int STAT_W   = 8;
  localparam int BIT_VOK  = 0;
  localparam int BIT_CBL  = 1;
  localparam int BIT_OCP  = 2;
  localparam int BIT_TSD  = 3;
  localparam int BIT_LDO  = 5;
  localparam int BIT_WARM = 6;
  localparam int N_STICKY = 2;
endpackage

// File: rtl/lnb_hiccup_seq.sv
`timescale 1ns/1ps
module lnb_hiccup_seq #(
  parameter int ON_TICKS  = 4000,
  parameter int OFF_TICKS = 128000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic tick_i,
  input  logic ocp_i,
  output logic drive_o,
  output logic trip_o
);
  import lnb_prot_pkg::*;

  localparam int CNT_MAX = (ON_TICKS > OFF_TICKS) ? ON_TICKS : OFF_TICKS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] ON_LAST  = CNT_W'(ON_TICKS - 1);
  localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_TICKS - 1);

  hc_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             trip_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    trip_d = 1'b0;
    if (!active_i) begin
      st_d  = HC_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        HC_IDLE: st_d = HC_RUN;
        HC_RUN: begin
          if (ocp_i) begin
            st_d  = HC_CLAMP;
            cnt_d = '0;
          end
        end
        HC_CLAMP: begin
          if (!ocp_i) begin
            st_d  = HC_RUN;
            cnt_d = '0;
          end else if (tick_i) begin
            if (cnt_q == ON_LAST) begin
              st_d   = HC_OFF;
              cnt_d  = '0;
              trip_d = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        HC_OFF: begin
          if (tick_i) begin
            if (cnt_q == OFF_LAST) begin
              st_d  = HC_RUN;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: st_d = HC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= HC_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign drive_o = (st_q == HC_RUN) || (st_q == HC_CLAMP);
  assign trip_o  = trip_d;
endmodule

// File: rtl/lnb_thermal_guard.sv
`timescale 1ns/1ps
module lnb_thermal_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic hot_i,
  input  logic cool_i,
  output logic off_o,
  output logic trip_o
);
  logic off_q, off_d;

  always_comb begin
    off_d = off_q;
    if (hot_i)       off_d = 1'b1;
    else if (cool_i) off_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_q <= 1'b0;
    else        off_q <= off_d;
  end

  assign off_o  = off_q;
  assign trip_o = hot_i && !off_q;
endmodule

// File: rtl/lnb_sticky_flag.sv
`timescale 1ns/1ps
module lnb_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q, q_d;

  always_comb q_d = set_i | (q_q & ~clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/lnb_prot_supervisor.sv
`timescale 1ns/1ps
module lnb_prot_supervisor #(
  parameter int ON_TICKS  = 4000,
  parameter int OFF_TICKS = 128000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       ctrl_mode_i,
  input  logic       out_en_bit_i,
  input  logic       en_pin_i,
  input  logic       status_rd_i,
  input  logic       ocp_flag_i,
  input  logic       hot_flag_i,
  input  logic       cool_flag_i,
  input  logic       warm_flag_i,
  input  logic       cable_flag_i,
  input  logic       vgood_flag_i,
  input  logic       ldo_on_i,
  output logic       reg_en_o,
  output logic [7:0] status_o,
  output logic       fault_n_o
);
  import lnb_prot_pkg::*;

  logic                active;
  logic                hc_drive, hc_trip;
  logic                th_off, th_trip;
  logic                pin_q;
  logic                pin_rise, clr_sel;
  logic [N_STICKY-1:0] set_v, q_v;

  assign active = en_pin_i & out_en_bit_i;

  // previous enable-pin level, for the pin-mode clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b1;
    else        pin_q <= en_pin_i;
  end

  assign pin_rise = en_pin_i & ~pin_q;
  assign clr_sel  = ctrl_mode_i ? status_rd_i : pin_rise;

  lnb_hiccup_seq #(.ON_TICKS(ON_TICKS), .OFF_TICKS(OFF_TICKS)) u_hiccup (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (active),
    .tick_i   (tick_i),
    .ocp_i    (ocp_flag_i),
    .drive_o  (hc_drive),
    .trip_o   (hc_trip)
  );

  lnb_thermal_guard u_thermal (
    .clk    (clk),
    .rst_n  (rst_n),
    .hot_i  (hot_flag_i),
    .cool_i (cool_flag_i),
    .off_o  (th_off),
    .trip_o (th_trip)
  );

  // index 0: overcurrent trip, index 1: thermal trip
  assign set_v = {th_trip, hc_trip};

  for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
    lnb_sticky_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_v[g]),
      .clr_i (clr_sel),
      .q_o   (q_v[g])
    );
  end

  assign reg_en_o = active & hc_drive & ~th_off;

  always_comb begin
    status_o           = '0;
    status_o[BIT_VOK]  = vgood_flag_i;
    status_o[BIT_CBL]  = cable_flag_i;
    status_o[BIT_OCP]  = q_v[0];
    status_o[BIT_TSD]  = q_v[1];
    status_o[BIT_LDO]  = ldo_on_i;
    status_o[BIT_WARM] = warm_flag_i;
  end

  assign fault_n_o = ~(q_v[0] | q_v[1] | warm_flag_i | ~vgood_flag_i);
endmodule

module lnb_prot_checker (
  input logic clk,
  input logic rst_n,
  input logic active_i,
  input logic ctrl_mode_i,
  input logic status_rd_i,
  input logic hot_i,
  input logic reg_en_i,
  input logic tsd_i,
  input logic ocp_i,
  input logic fault_n_i
);
  p_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> (!reg_en_i || active_i));

  p_hot_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hot_i |=> !reg_en_i);

  p_ocp_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ocp_i) |-> !reg_en_i);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_mode_i && !status_rd_i && (tsd_i || ocp_i)) |=> (tsd_i || ocp_i));

  p_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tsd_i || ocp_i) |-> !fault_n_i);
endmodule

bind lnb_prot_supervisor lnb_prot_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .active_i    (active),
  .ctrl_mode_i (ctrl_mode_i),
  .status_rd_i (status_rd_i),
  .hot_i       (hot_flag_i),
  .reg_en_i    (reg_en_o),
  .tsd_i       (status_o[3]),
  .ocp_i       (status_o[2]),
  .fault_n_i   (fault_n_o)
);

// File: tb/lnb_prot_supervisor_tb.sv
`timescale 1ns/1ps
module lnb_prot_supervisor_tb;
  localparam int ON_T  = 4;
  localparam int OFF_T = 8;

  logic clk = 1'b0;
  logic rst_n, tick, mode, en_bit, pin, rd;
  logic ocp, hot, cool, warm, cable, vgood, ldo;
  logic reg_en, fault_n;
  logic [7:0] status;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lnb_prot_supervisor #(.ON_TICKS(ON_T), .OFF_TICKS(OFF_T)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .ctrl_mode_i(mode),
    .out_en_bit_i(en_bit), .en_pin_i(pin), .status_rd_i(rd),
    .ocp_flag_i(ocp), .hot_flag_i(hot), .cool_flag_i(cool),
    .warm_flag_i(warm), .cable_flag_i(cable), .vgood_flag_i(vgood),
    .ldo_on_i(ldo), .reg_en_o(reg_en), .status_o(status), .fault_n_o(fault_n)
  );

  function automatic logic [7:0] exp_status(logic w, logic l, logic t, logic o,
                                            logic c, logic v);
    return {1'b0, w, l, 1'b0, t, o, c, v};
  endfunction

  function automatic logic exp_fault_n(logic t, logic o, logic w, logic v);
    return ~(t | o | w | ~v);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic read_pulse();
    rd = 1'b1; step(1); rd = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tick = 1; mode = 1; en_bit = 1; pin = 1; rd = 0;
    ocp = 0; hot = 0; cool = 0; warm = 0; cable = 0; vgood = 1; ldo = 0;
    step(3);
    check("R1 reg_en in reset", 8'(reg_en), 8'd0);
    check("R1 sticky bits in reset", 8'(status[3:2]), 8'd0);
    rst_n = 1;
    step(1);
    check("R11 enabled after idle", 8'(reg_en), 8'd1);

    // R2 / R3 full hiccup cycle
    ocp = 1;
    for (int k = 1; k <= ON_T; k++) begin
      step(1);
      check("R2 clamp window on", 8'(reg_en), 8'd1);
    end
    step(1);
    check("R2 shutdown at window end", 8'(reg_en), 8'd0);
    check("R2 overcurrent bit set", 8'(status[2]), 8'd1);
    check("R10 fault low on trip", 8'(fault_n), 8'd0);
    for (int k = 1; k < OFF_T; k++) begin
      step(1);
      check("R3 rest window off", 8'(reg_en), 8'd0);
    end
    step(1);
    check("R3 retry after rest", 8'(reg_en), 8'd1);
    ocp = 0;
    step(2);
    check("R6 overcurrent bit held", 8'(status[2]), 8'd1);
    read_pulse();
    check("R6 read clears", 8'(status[3:2]), 8'd0);
    check("R10 fault released", 8'(fault_n), 8'd1);

    // R4 short overcurrent
    ocp = 1; step(2); ocp = 0; step(1);
    check("R4 still enabled", 8'(reg_en), 8'd1);
    step(6);
    check("R4 no trip latched", 8'(status[2]), 8'd0);
    check("R4 enabled later", 8'(reg_en), 8'd1);

    // R3 tick gating, then R11 abort of rest window
    ocp = 1; tick = 0;
    step(20);
    check("R3 no tick no timeout", 8'(reg_en), 8'd1);
    tick = 1;
    step(3);
    check("R3 counting resumes", 8'(reg_en), 8'd1);
    step(1);
    check("R3 shutdown after ticks", 8'(reg_en), 8'd0);
    en_bit = 0; step(1);
    check("R11 bit low disables", 8'(reg_en), 8'd0);
    en_bit = 1; ocp = 0; step(1);
    check("R11 restart skips rest", 8'(reg_en), 8'd1);
    read_pulse();

    // R5 thermal hysteresis
    hot = 1; step(1);
    check("R5 hot disables", 8'(reg_en), 8'd0);
    check("R5 thermal bit set", 8'(status[3]), 8'd1);
    hot = 0; step(3);
    check("R5 stays off until cool", 8'(reg_en), 8'd0);
    cool = 1; step(1); cool = 0;
    check("R5 cool re-enables", 8'(reg_en), 8'd1);
    read_pulse();
    check("R6 thermal cleared by read", 8'(status[3]), 8'd0);

    // R8 set wins over clear
    hot = 1; rd = 1; step(1); hot = 0; rd = 0;
    check("R8 set beats read", 8'(status[3]), 8'd1);
    cool = 1; step(1); cool = 0;
    read_pulse();

    // R7 pin mode
    mode = 0;
    hot = 1; step(1); hot = 0; cool = 1; step(1); cool = 0;
    read_pulse();
    check("R7 read ignored in pin mode", 8'(status[3]), 8'd1);
    pin = 0; step(1);
    check("R11 pin low disables", 8'(reg_en), 8'd0);
    check("R7 held while pin low", 8'(status[3]), 8'd1);
    pin = 1; step(1);
    check("R7 pin cycle clears", 8'(status[3]), 8'd0);
    check("R11 pin high enables", 8'(reg_en), 8'd1);
    mode = 1;

    // R9 / R10 random non-sticky flags
    void'($urandom(32'd1234));
    for (int i = 0; i < 300; i++) begin
      warm = 1'($urandom); cable = 1'($urandom);
      vgood = 1'($urandom); ldo = 1'($urandom); tick = 1'($urandom);
      #1;
      check("R9 status layout", status,
            exp_status(warm, ldo, 1'b0, 1'b0, cable, vgood));
      check("R10 fault line", 8'(fault_n),
            8'(exp_fault_n(1'b0, 1'b0, warm, vgood)));
      step(1);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule